// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit

This unit is the carry-propagating arithmetic path of an accumulator-style processor. It takes an accumulator value, a memory operand, the incoming carry flag, a decimal-mode flag, an operation select (add with carry, or subtract with borrow) and a width select (8 or 16 bits). It returns the new accumulator value and the carry, overflow, negative and zero flags.

The datapath is a chain of four-bit digit stages. In binary mode each stage is a plain four-bit adder slice. In decimal mode each stage also applies its own packed-BCD correction and passes its carry to the next stage. For subtraction the operand is inverted at the selected width and goes through the same chain, with the incoming carry acting as "no borrow". The overflow flag is taken from the raw sum of the most significant digit, before that digit is corrected. A clock-enabled register stage holds the outputs. Each result appears one clock after it is presented with the enable high.

Top module: `bcd_addsub_unit`

## Requirements
- R1: In binary add mode, the result equals accumulator + operand + carry-in, truncated to the selected width (8 or 16 bits). Carry-out is 1 exactly when the untruncated sum exceeds the all-ones value of that width.
- R2: With the subtract select high, the operand is replaced by its ones' complement at the selected width before the add of R1. A carry-in of 1 therefore means no borrow, and a carry-out of 0 signals that a borrow occurred.
- R3: Overflow is 1 exactly when the accumulator and the effective operand (the inverted operand for subtract) share a sign bit at the selected width, and the raw sum's sign bit differs from it. In decimal mode the raw sum is taken before the most significant digit is corrected.
- R4: In decimal add, every digit whose raw sum (two digits plus incoming carry) exceeds 9 is corrected by +6. Its carry to the next digit is 1 when the corrected value exceeds 15. With valid BCD operands every result digit is 0 to 9.
- R5: In decimal subtract, every digit whose raw sum is 15 or less is corrected by -6, modulo 16. Its carry to the next digit is 1 exactly when the raw sum exceeds 15.
- R6: The most significant digit (digit 1 in 8-bit mode, digit 3 in 16-bit mode) is corrected in the same way. Its outgoing carry is the carry-out flag.
- R7: Negative is the top bit of the result at the selected width. Zero is 1 exactly when the result at that width is all zeros. The two are never both 1.
- R8: In 8-bit mode the upper byte of the result output is the upper byte of the accumulator input, unchanged.
- R9: The outputs change only on a rising clock edge where the enable is high. They then show the result and flags of the inputs sampled at that edge. With the enable low they hold.
- R10: While reset is asserted, the result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clock enable for the output register |
| acc_i | input | 16 | Accumulator operand |
| opd_i | input | 16 | Memory operand |
| carry_i | input | 1 | Incoming carry flag (no-borrow for subtract) |
| dec_i | input | 1 | 1 = packed BCD arithmetic |
| sub_i | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |
| neg_o | output | 1 | Registered negative flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
The digit-range assertion checks decimal digits only when both input digits are valid BCD. For a subtract, that means the inverted operand digit is 6 or more. It makes no claim about results from non-BCD operands. The binary sum and overflow assertions apply only in binary mode, and the register-level properties assume the enable and the selects are driven to known values after reset. The random decimal stimulus builds every operand from digits 0 to 9. Binary stimulus uses arbitrary 16-bit values, and the hand-written table covers the carry, borrow, overflow and pass-through corners.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic neg;
    logic zero;
  } flags_t;

endpackage

// File: rtl/addsub_digit.sv
module addsub_digit
  import addsub_pkg::*;
#(
  parameter int DW = DIGIT_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          dec_i,
  input  logic          sub_i,
  output logic [DW-1:0] digit_o,
  output logic          cout_o,
  output logic          raw_msb_o
);

  // Two guard bits: room for the +6 on a 31 sum, and for the wrap of a -6.
  localparam int SW = DW + 2;
  localparam logic [SW-1:0] DEC_MAX  = SW'(9);
  localparam logic [SW-1:0] DIG_MAX  = SW'((1 << DW) - 1);
  localparam logic [SW-1:0] DEC_ADJ  = SW'(6);

  logic [SW-1:0] raw_sum;
  logic [SW-1:0] adj_sum;
  logic          carry_out;

  assign raw_sum = {2'b00, a_i} + {2'b00, b_i} + {{(SW-1){1'b0}}, cin_i};

  always_comb begin
    adj_sum   = raw_sum;
    carry_out = raw_sum[DW];
    if (dec_i) begin
      if (!sub_i) begin
        if (raw_sum > DEC_MAX) adj_sum = raw_sum + DEC_ADJ;
        carry_out = |adj_sum[SW-1:DW];
      end else begin
        if (raw_sum <= DIG_MAX) adj_sum = raw_sum - DEC_ADJ;
        carry_out = (raw_sum > DIG_MAX);
      end
    end
  end

  assign digit_o   = adj_sum[DW-1:0];
  assign cout_o    = carry_out;
  assign raw_msb_o = raw_sum[DW-1];

  // R4/R5: valid BCD digits in give a valid BCD digit out
  always_comb begin
    if (dec_i && (a_i <= DW'(9)) && (sub_i ? (b_i >= DW'(6)) : (b_i <= DW'(9)))) begin
      p_bcd_digit_r4: assert (digit_o <= DW'(9));
    end
  end

endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic              carry_i,
  input  logic              dec_i,
  input  logic              sub_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o,
  output flags_t            flags_o
);

  localparam int NDIG      = DATA_W / DIGIT_W;
  localparam int NDIG_NARR = NARROW_W / DIGIT_W;
  localparam int IDX_W     = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [IDX_W-1:0] TOP_WIDE = IDX_W'(NDIG - 1);
  localparam logic [IDX_W-1:0] TOP_NARR = IDX_W'(NDIG_NARR - 1);

  logic [DATA_W-1:0] opd_eff;
  logic [DATA_W-1:0] digits;
  logic [NDIG:0]     chain_c;
  logic [NDIG-1:0]   raw_msb;
  logic [IDX_W-1:0]  top_idx;
  logic              acc_sign;
  logic              opd_sign;
  logic              raw_sign;

  assign opd_eff    = sub_i ? ~opd_i : opd_i;
  assign chain_c[0] = carry_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    addsub_digit #(.DW(DIGIT_W)) u_digit (
      .a_i      (acc_i[g*DIGIT_W +: DIGIT_W]),
      .b_i      (opd_eff[g*DIGIT_W +: DIGIT_W]),
      .cin_i    (chain_c[g]),
      .dec_i    (dec_i),
      .sub_i    (sub_i),
      .digit_o  (digits[g*DIGIT_W +: DIGIT_W]),
      .cout_o   (chain_c[g+1]),
      .raw_msb_o(raw_msb[g])
    );
  end

  assign top_idx  = wide_i ? TOP_WIDE : TOP_NARR;
  assign raw_sign = raw_msb[top_idx];

  always_comb begin
    if (wide_i) begin
      result_o      = digits;
      flags_o.carry = chain_c[NDIG];
      acc_sign      = acc_i[DATA_W-1];
      opd_sign      = opd_eff[DATA_W-1];
      flags_o.neg   = digits[DATA_W-1];
      flags_o.zero  = (digits == '0);
    end else begin
      result_o      = {acc_i[DATA_W-1:NARROW_W], digits[NARROW_W-1:0]};
      flags_o.carry = chain_c[NDIG_NARR];
      acc_sign      = acc_i[NARROW_W-1];
      opd_sign      = opd_eff[NARROW_W-1];
      flags_o.neg   = digits[NARROW_W-1];
      flags_o.zero  = (digits[NARROW_W-1:0] == '0);
    end
    flags_o.ovf = (acc_sign == opd_sign) && (raw_sign != acc_sign);
  end

  // Reference arithmetic for the binary-mode checks below
  logic [DATA_W:0]   chk_sum;
  logic [DATA_W+1:0] chk_ssum;
  assign chk_sum  = {1'b0, acc_i} + {1'b0, opd_eff} + {{DATA_W{1'b0}}, carry_i};
  assign chk_ssum = {{2{acc_i[DATA_W-1]}}, acc_i} + {{2{opd_eff[DATA_W-1]}}, opd_eff}
                  + {{(DATA_W+1){1'b0}}, carry_i};

  always_comb begin
    if (!dec_i && wide_i) begin
      p_bin_sum_r1: assert ({flags_o.carry, result_o} == chk_sum);
      p_bin_ovf_r3: assert (flags_o.ovf == (chk_ssum[DATA_W] != chk_ssum[DATA_W-1]));
    end
  end

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic              carry_i,
  input  logic              dec_i,
  input  logic              sub_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              neg_o,
  output logic              zero_o
);

  logic [DATA_W-1:0] core_res;
  flags_t            core_flags;
  logic [DATA_W-1:0] res_d, res_q;
  flags_t            flags_d, flags_q;

  addsub_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .acc_i   (acc_i),
    .opd_i   (opd_i),
    .carry_i (carry_i),
    .dec_i   (dec_i),
    .sub_i   (sub_i),
    .wide_i  (wide_i),
    .result_o(core_res),
    .flags_o (core_flags)
  );

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    if (en_i) begin
      res_d   = core_res;
      flags_d = core_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = flags_q.carry;
  assign ovf_o    = flags_q.ovf;
  assign neg_o    = flags_q.neg;
  assign zero_o   = flags_q.zero;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(result_o) && $stable(carry_o) && $stable(ovf_o)
               && $stable(neg_o) && $stable(zero_o)));

  p_narrow_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wide_i) |=> (result_o[DATA_W-1:NARROW_W] == $past(acc_i[DATA_W-1:NARROW_W])));

  p_neg_zero_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(neg_o && zero_o));

endmodule

// File: tb/bcd_addsub_unit_tb.sv
module bcd_addsub_unit_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] acc;
    logic [15:0] opd;
    logic        cin;
    logic        dec;
    logic        sub;
    logic        wide;
    logic [15:0] res;
    logic        c;
    logic        v;
    logic        n;
    logic        z;
  } vec_t;

  typedef struct packed {
    logic [15:0] res;
    logic        c;
    logic        v;
    logic        n;
    logic        z;
  } out_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{16'h1234, 16'h0050, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1284, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h8000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'hAB05, 16'h0007, 1'b1, 1'b0, 1'b1, 1'b0, 16'hABFE, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h0099, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h1234, 16'h5678, 1'b1, 1'b1, 1'b0, 1'b1, 16'h6913, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h1000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0999, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h0050, 16'h0030, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0020, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h0079, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0080, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'hBE45, 16'h7755, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBE00, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [15:0] acc_i, opd_i;
  logic        carry_i, dec_i, sub_i, wide_i;
  logic [15:0] result_o;
  logic        carry_o, ovf_o, neg_o, zero_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_addsub_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .acc_i   (acc_i),
    .opd_i   (opd_i),
    .carry_i (carry_i),
    .dec_i   (dec_i),
    .sub_i   (sub_i),
    .wide_i  (wide_i),
    .result_o(result_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .neg_o   (neg_o),
    .zero_o  (zero_o)
  );

  // Whole-value model built from the requirements
  function automatic out_t model(input logic [15:0] a16, input logic [15:0] b16,
                                 input logic ci, input logic dec, input logic sub,
                                 input logic wide);
    int w, nd, mask, a, b, r, cy, sgn, lo, t;
    out_t o;
    w    = wide ? 16 : 8;
    nd   = w / 4;
    mask = (1 << w) - 1;
    sgn  = 1 << (w - 1);
    a    = int'(a16) & mask;
    b    = int'(b16) & mask;
    if (sub) b = b ^ mask;
    if (!dec) begin
      r = a + b + int'(ci);
    end else begin
      r  = 0;
      cy = int'(ci);
      for (int k = 0; k < nd - 1; k++) begin
        lo = (1 << (4*k)) - 1;
        r  = (a & (15 << (4*k))) + (b & (15 << (4*k))) + (cy << (4*k)) + (r & lo);
        if (!sub) begin
          if (r > ((10 << (4*k)) - 1)) r = r + (6 << (4*k));
        end else begin
          if (r <= ((16 << (4*k)) - 1)) r = r - (6 << (4*k));
        end
        cy = (r > ((16 << (4*k)) - 1)) ? 1 : 0;
      end
      t  = 4 * (nd - 1);
      r  = (a & (15 << t)) + (b & (15 << t)) + (cy << t) + (r & ((1 << t) - 1));
    end
    o.v = ((~(a ^ b)) & (a ^ r) & sgn) != 0;
    if (dec) begin
      t = 4 * (nd - 1);
      if (!sub) begin
        if (r > ((10 << t) - 1)) r = r + (6 << t);
      end else begin
        if (r <= mask) r = r - (6 << t);
      end
    end
    o.c = (r > mask);
    o.n = (r & sgn) != 0;
    o.z = (r & mask) == 0;
    if (wide) o.res = 16'(r & mask);
    else      o.res = {a16[15:8], 8'(r & mask)};
    return o;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out(input out_t e, input logic dec, input logic sub, input logic wide);
    string rtag;
    rtag = dec ? (sub ? "R5" : "R4") : (sub ? "R2" : "R1");
    check(rtag, result_o, e.res);
    if (!wide) check("R8 upper byte", {8'h00, result_o[15:8]}, {8'h00, e.res[15:8]});
    check(dec ? "R6 carry" : "R1 carry", {15'h0, carry_o}, {15'h0, e.c});
    check("R3 overflow", {15'h0, ovf_o}, {15'h0, e.v});
    check("R7 neg/zero", {14'h0, neg_o, zero_o}, {14'h0, e.n, e.z});
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci,
                       input logic dec, input logic sub, input logic wide);
    @(negedge clk);
    en_i = 1'b1; acc_i = a; opd_i = b; carry_i = ci;
    dec_i = dec; sub_i = sub; wide_i = wide;
    @(negedge clk);
  endtask

  function automatic logic [15:0] rand_bcd();
    logic [15:0] v;
    for (int k = 0; k < 4; k++) v[4*k +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    out_t e;
    logic [15:0] held;
    rst_n = 1'b0; en_i = 1'b0; acc_i = 16'hFFFF; opd_i = 16'hFFFF;
    carry_i = 1'b1; dec_i = 1'b0; sub_i = 1'b0; wide_i = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", result_o, 16'h0000);
    check("R10 flags", {12'h0, carry_o, ovf_o, neg_o, zero_o}, 16'h0000);
    rst_n = 1'b1;

    // Table of hand-worked corners
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].acc, VECS[i].opd, VECS[i].cin, VECS[i].dec, VECS[i].sub, VECS[i].wide);
      e = '{VECS[i].res, VECS[i].c, VECS[i].v, VECS[i].n, VECS[i].z};
      check_out(e, VECS[i].dec, VECS[i].sub, VECS[i].wide);
    end

    // Random binary and BCD patterns against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      logic ci, dec, sub, wide;
      dec  = 1'($urandom);
      sub  = 1'($urandom);
      wide = 1'($urandom);
      ci   = 1'($urandom);
      a    = dec ? rand_bcd() : 16'($urandom);
      b    = dec ? rand_bcd() : 16'($urandom);
      if (dec && !wide) a[15:8] = 8'($urandom);
      apply(a, b, ci, dec, sub, wide);
      check_out(model(a, b, ci, dec, sub, wide), dec, sub, wide);
    end

    // R9: enable low holds the outputs while the inputs change
    apply(16'h0042, 16'h0017, 1'b0, 1'b1, 1'b0, 1'b1);
    held = result_o;
    check("R9 loaded", held, 16'h0059);
    @(negedge clk);
    en_i = 1'b0; acc_i = 16'h9999; opd_i = 16'h9999; sub_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 hold result", result_o, held);
    check("R9 hold flags", {12'h0, carry_o, ovf_o, neg_o, zero_o}, 16'h0000);
    en_i = 1'b1;
    @(negedge clk);
    e = model(16'h9999, 16'h9999, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 resume", result_o, e.res);

    // R10: reset asserted mid-run clears the outputs at once
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 negative", {15'h0, neg_o}, 16'h0001);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #(CLK_PERIOD/8);
    check("R10 async result", result_o, 16'h0000);
    check("R10 async flags", {12'h0, carry_o, ovf_o, neg_o, zero_o}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule